// File: doc/BRIEF.md
# EEPROM Page Write Host Controller

This block sits on the host side of a parallel EEPROM and programs one page of 1 to 64 bytes per command. A command gives the page number (the upper address bits), the number of bytes minus one and a completion-detection mode. Bytes then arrive on a valid/ready stream, each carrying its offset inside the page and its value. For every byte the controller generates a chip-enable / write-enable strobe with output enable held high. The setup, pulse and hold lengths are parameters counted in clock cycles. The controller keeps the gap between successive write-enable falls inside the device's load window. If the stream stalls too long, it abandons the page and reports an underrun.

After the last byte strobe the controller polls the device until its internal programming cycle ends. It issues read strobes at the last written address and samples the bus a parameterised number of cycles after output enable falls. In bit-7 mode it waits until bit 7 of the read data equals bit 7 of the last written byte. In toggle mode it waits until bit 6 holds the same value on two consecutive reads. A bounded number of reads without completion ends the command with a timeout.

The sequencer states are IDLE, WAIT_BYTE, SETUP, STROBE, HOLD, READ, EVAL and DONE. Their transitions are:
- IDLE to WAIT_BYTE on start.
- WAIT_BYTE to SETUP on an accepted byte, or to DONE on underrun.
- SETUP to STROBE to HOLD, each after its parameter count.
- HOLD to WAIT_BYTE while bytes remain, or to READ after the last byte.
- READ to EVAL after the read delay.
- EVAL to DONE on completion or timeout, otherwise back to READ.
- DONE to IDLE.

Top module: `eeprom_page_writer`

## Requirements
- R1: A start_i pulse seen in IDLE latches page_i, count_i and mode_i. busy_o is high from the next cycle until the block returns to IDLE one cycle after done_o.
- R2: Every write strobe drives ee_addr_o = {page, offset}, where the page occupies the upper PAGE_BITS bits and the offset the lower OFS_BITS bits. The page bits are identical for all strobes of one command.
- R3: Each write strobe holds ee_ce_n_o low, ee_oe_n_o high and ee_drive_o high for SETUP_CYC cycles before ee_we_n_o falls. ee_we_n_o stays low exactly PULSE_CYC cycles. Address and data stay stable while it is low, and are held for HOLD_CYC cycles after it rises.
- R4: byte_ready_o is high only while waiting for a byte. Exactly count_i+1 bytes (count_i = bytes minus one, 0..63) are accepted, and each is written once with its own value at its own offset, in arrival order.
- R5: If, after the first byte, GAP_LIMIT cycles pass since the last write-enable fall while no byte is accepted, no further strobe is issued. done_o then reports status 2 (underrun).
- R6: With mode_i = 0 (bit-7 polling), the block reports status 0 once a read of the last written address returns bit 7 equal to bit 7 of the last written byte.
- R7: With mode_i = 1 (toggle detection), the block reports status 0 once two consecutive reads return the same bit 6.
- R8: During a poll read, ee_ce_n_o and ee_oe_n_o are low, ee_we_n_o is high and ee_drive_o is low. ee_poll_i (bit 1 = bus bit 7, bit 0 = bus bit 6) is sampled on the RD_DLY-th clock edge after ee_oe_n_o falls.
- R9: If POLL_MAX reads complete without success, done_o reports status 1 (timeout).
- R10: done_o is a single-cycle pulse per command. status_o is 0 (ok), 1 (timeout) or 2 (underrun) while done_o is high.
- R11: After reset ee_ce_n_o, ee_we_n_o and ee_oe_n_o are high, while busy_o, done_o, byte_ready_o and ee_drive_o are low.
- R12: start_i is ignored while busy_o is high. The running command keeps its page, byte count and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Command start pulse |
| page_i | input | PAGE_BITS | Page number (upper address bits) |
| count_i | input | OFS_BITS | Number of bytes minus one |
| mode_i | input | 1 | 0 = bit-7 polling, 1 = toggle detection |
| busy_o | output | 1 | Command in progress |
| byte_valid_i | input | 1 | Stream byte valid |
| byte_offset_i | input | OFS_BITS | Offset of the byte within the page |
| byte_data_i | input | DATA_W | Byte value |
| byte_ready_o | output | 1 | Stream byte accepted when high with valid |
| ee_addr_o | output | PAGE_BITS+OFS_BITS | Device address |
| ee_dout_o | output | DATA_W | Write data to the device |
| ee_drive_o | output | 1 | Enable for the data bus drivers |
| ee_ce_n_o | output | 1 | Chip enable, active low |
| ee_we_n_o | output | 1 | Write enable, active low |
| ee_oe_n_o | output | 1 | Output enable, active low |
| ee_poll_i | input | 2 | Read bus bits 7 and 6 |
| done_o | output | 1 | Command finished pulse |
| status_o | output | 2 | Result code, valid with done_o |

## Verification
The main function is driven from a vector table. It varies the byte count (1, 3 to 6, 17, 64), the polling mode, the written bit 7 and the length of the device's programming period, and it uses offset orders that are permutations of the page. A single-byte page with bit 7 clear and another with it set show that bit-7 polling compares against the written value and not a constant. Long programming periods in both modes separate true completion from a timeout, and show that toggle detection never finishes while bit 6 keeps flipping. A short stall between bytes is accepted, while a long one must give an underrun after exactly one written byte. A device model that presents wrong data until the intended sample cycle exposes early sampling, and a second start issued mid-command must leave the page untouched.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_BYTE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_READ,
        ST_EVAL,
        ST_DONE
    } pgw_state_e;

    typedef enum logic [1:0] {
        RES_OK       = 2'd0,
        RES_TIMEOUT  = 2'd1,
        RES_UNDERRUN = 2'd2
    } pgw_result_e;

    localparam logic POLL_BIT7   = 1'b0;
    localparam logic POLL_TOGGLE = 1'b1;

endpackage

// File: rtl/pgw_gap_timer.sv
// Counts cycles since the most recent write-enable fall; saturates at LIMIT.
module pgw_gap_timer #(
    parameter int LIMIT = 30000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic expired_o
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (cnt_q != W'(LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q == W'(LIMIT));
endmodule

// File: rtl/pgw_poll_judge.sv
// Decides from the latest poll sample whether the programming cycle ended.
module pgw_poll_judge (
    input  logic mode_i,
    input  logic ref_stat_i,
    input  logic samp_stat_i,
    input  logic samp_tog_i,
    input  logic prev_tog_i,
    input  logic have_prev_i,
    output logic finished_o
);
    import pgw_pkg::*;

    always_comb begin
        if (mode_i == POLL_TOGGLE) begin
            finished_o = have_prev_i && (samp_tog_i == prev_tog_i);
        end else begin
            finished_o = (samp_stat_i == ref_stat_i);
        end
    end
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
    parameter int PAGE_BITS = 9,
    parameter int OFS_BITS  = 6,
    parameter int DATA_W    = 8,
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 3,
    parameter int HOLD_CYC  = 1,
    parameter int GAP_LIMIT = 30000,
    parameter int RD_DLY    = 2,
    parameter int POLL_MAX  = 4096
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [PAGE_BITS-1:0]          page_i,
    input  logic [OFS_BITS-1:0]           count_i,
    input  logic                          mode_i,
    output logic                          busy_o,
    input  logic                          byte_valid_i,
    input  logic [OFS_BITS-1:0]           byte_offset_i,
    input  logic [DATA_W-1:0]             byte_data_i,
    output logic                          byte_ready_o,
    output logic [PAGE_BITS+OFS_BITS-1:0] ee_addr_o,
    output logic [DATA_W-1:0]             ee_dout_o,
    output logic                          ee_drive_o,
    output logic                          ee_ce_n_o,
    output logic                          ee_we_n_o,
    output logic                          ee_oe_n_o,
    input  logic [1:0]                    ee_poll_i,
    output logic                          done_o,
    output logic [1:0]                    status_o
);
    import pgw_pkg::*;

    localparam int CNT_W  = 16;
    localparam int POLL_W = $clog2(POLL_MAX + 1);

    pgw_state_e            state_q, state_d;
    logic [CNT_W-1:0]      cnt_q;
    logic [PAGE_BITS-1:0]  page_q;
    logic [OFS_BITS-1:0]   off_q;
    logic [OFS_BITS-1:0]   left_q;
    logic [DATA_W-1:0]     data_q;
    logic                  mode_q;
    logic                  first_q;
    logic                  last_q;
    logic [1:0]            samp_q;
    logic                  prev_tog_q;
    logic                  have_prev_q;
    logic [POLL_W-1:0]     polls_q;
    pgw_result_e           status_q;

    logic gap_expired;
    logic gap_restart;
    logic poll_finished;
    logic underrun;
    logic poll_exhausted;

    // Timer restarts on the first cycle with write enable low.
    assign gap_restart = (state_q == ST_STROBE) && (cnt_q == '0);

    pgw_gap_timer #(
        .LIMIT (GAP_LIMIT)
    ) gap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (gap_restart),
        .expired_o (gap_expired)
    );

    pgw_poll_judge judge_i (
        .mode_i      (mode_q),
        .ref_stat_i  (data_q[DATA_W-1]),
        .samp_stat_i (samp_q[1]),
        .samp_tog_i  (samp_q[0]),
        .prev_tog_i  (prev_tog_q),
        .have_prev_i (have_prev_q),
        .finished_o  (poll_finished)
    );

    assign underrun       = !first_q && gap_expired;
    assign poll_exhausted = (polls_q == POLL_W'(POLL_MAX - 1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_WAIT_BYTE;
            ST_WAIT_BYTE: begin
                if (underrun)          state_d = ST_DONE;
                else if (byte_valid_i) state_d = ST_SETUP;
            end
            ST_SETUP:     if (cnt_q == CNT_W'(SETUP_CYC - 1)) state_d = ST_STROBE;
            ST_STROBE:    if (cnt_q == CNT_W'(PULSE_CYC - 1)) state_d = ST_HOLD;
            ST_HOLD: begin
                if (cnt_q == CNT_W'(HOLD_CYC - 1))
                    state_d = last_q ? ST_READ : ST_WAIT_BYTE;
            end
            ST_READ:      if (cnt_q == CNT_W'(RD_DLY - 1)) state_d = ST_EVAL;
            ST_EVAL:      state_d = (poll_finished || poll_exhausted) ? ST_DONE : ST_READ;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Command and poll datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            page_q      <= '0;
            off_q       <= '0;
            left_q      <= '0;
            data_q      <= '0;
            mode_q      <= POLL_BIT7;
            first_q     <= 1'b1;
            last_q      <= 1'b0;
            samp_q      <= '0;
            prev_tog_q  <= 1'b0;
            have_prev_q <= 1'b0;
            polls_q     <= '0;
            status_q    <= RES_OK;
        end else begin
            cnt_q <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        page_q      <= page_i;
                        left_q      <= count_i;
                        mode_q      <= mode_i;
                        first_q     <= 1'b1;
                        polls_q     <= '0;
                        have_prev_q <= 1'b0;
                        status_q    <= RES_OK;
                    end
                end
                ST_WAIT_BYTE: begin
                    if (underrun) begin
                        status_q <= RES_UNDERRUN;
                    end else if (byte_valid_i) begin
                        off_q  <= byte_offset_i;
                        data_q <= byte_data_i;
                        last_q <= (left_q == '0);
                        left_q <= left_q - 1'b1;
                    end
                end
                ST_STROBE: first_q <= 1'b0;
                ST_READ: begin
                    if (cnt_q == CNT_W'(RD_DLY - 1)) samp_q <= ee_poll_i;
                end
                ST_EVAL: begin
                    if (poll_finished) begin
                        status_q <= RES_OK;
                    end else if (poll_exhausted) begin
                        status_q <= RES_TIMEOUT;
                    end else begin
                        prev_tog_q  <= samp_q[0];
                        have_prev_q <= 1'b1;
                        polls_q     <= polls_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        ee_ce_n_o    = 1'b1;
        ee_we_n_o    = 1'b1;
        ee_oe_n_o    = 1'b1;
        ee_drive_o   = 1'b0;
        byte_ready_o = 1'b0;
        done_o       = 1'b0;
        unique case (state_q)
            ST_IDLE:      ;
            ST_WAIT_BYTE: byte_ready_o = !underrun;
            ST_SETUP: begin
                ee_ce_n_o  = 1'b0;
                ee_drive_o = 1'b1;
            end
            ST_STROBE: begin
                ee_ce_n_o  = 1'b0;
                ee_we_n_o  = 1'b0;
                ee_drive_o = 1'b1;
            end
            ST_HOLD: begin
                ee_ce_n_o  = 1'b0;
                ee_drive_o = 1'b1;
            end
            ST_READ: begin
                ee_ce_n_o = 1'b0;
                ee_oe_n_o = 1'b0;
            end
            ST_EVAL:      ;
            ST_DONE:      done_o = 1'b1;
            default:      ;
        endcase
    end

    assign busy_o    = (state_q != ST_IDLE);
    assign status_o  = status_q;
    assign ee_addr_o = {page_q, off_q};
    assign ee_dout_o = data_q;

endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
    parameter int PAGE_BITS = 9,
    parameter int OFS_BITS  = 6,
    parameter int DATA_W    = 8,
    parameter int PULSE_CYC = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          start_i,
    input logic                          busy_o,
    input logic                          byte_ready_o,
    input logic [PAGE_BITS+OFS_BITS-1:0] ee_addr_o,
    input logic [DATA_W-1:0]             ee_dout_o,
    input logic                          ee_drive_o,
    input logic                          ee_ce_n_o,
    input logic                          ee_we_n_o,
    input logic                          ee_oe_n_o,
    input logic                          done_o,
    input logic [1:0]                    status_o
);
    localparam int AW = PAGE_BITS + OFS_BITS;

    logic [15:0]          low_cnt_q;
    logic                 seen_q;
    logic [PAGE_BITS-1:0] page_seen_q;
    logic                 we_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt_q   <= '0;
            seen_q      <= 1'b0;
            page_seen_q <= '0;
            we_prev_q   <= 1'b1;
        end else begin
            low_cnt_q <= ee_we_n_o ? 16'd0 : low_cnt_q + 16'd1;
            we_prev_q <= ee_we_n_o;
            if (start_i && !busy_o) begin
                seen_q <= 1'b0;
            end else if (we_prev_q && !ee_we_n_o) begin
                seen_q      <= 1'b1;
                page_seen_q <= ee_addr_o[AW-1:OFS_BITS];
            end
        end
    end

    AST_WRITE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_we_n_o |-> (!ee_ce_n_o && ee_oe_n_o && ee_drive_o)); // R3
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_we_n_o) |-> (low_cnt_q == 16'(PULSE_CYC))); // R3
    AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ee_we_n_o && !$fell(ee_we_n_o)) |-> ($stable(ee_addr_o) && $stable(ee_dout_o))); // R3
    AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ee_we_n_o) && seen_q) |-> (ee_addr_o[AW-1:OFS_BITS] == page_seen_q)); // R2
    AST_READ_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_oe_n_o |-> (!ee_drive_o && ee_we_n_o)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (status_o != 2'd3)); // R10
    AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> busy_o); // R4
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o); // R1

endmodule

bind eeprom_page_writer pgw_checker #(
    .PAGE_BITS (PAGE_BITS),
    .OFS_BITS  (OFS_BITS),
    .DATA_W    (DATA_W),
    .PULSE_CYC (PULSE_CYC)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .byte_ready_o (byte_ready_o),
    .ee_addr_o    (ee_addr_o),
    .ee_dout_o    (ee_dout_o),
    .ee_drive_o   (ee_drive_o),
    .ee_ce_n_o    (ee_ce_n_o),
    .ee_we_n_o    (ee_we_n_o),
    .ee_oe_n_o    (ee_oe_n_o),
    .done_o       (done_o),
    .status_o     (status_o)
);

// File: tb/eeprom_page_writer_tb_top.sv
`timescale 1ns/1ps
module eeprom_page_writer_tb_top;
    localparam int SETUP = 2;
    localparam int PULSE = 3;
    localparam int HOLD  = 1;
    localparam int GAP   = 40;
    localparam int RD    = 2;
    localparam int PMAX  = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [8:0]  page_i = '0;
    logic [5:0]  count_i = '0;
    logic        mode_i = 1'b0;
    logic        busy_o;
    logic        byte_valid_i = 1'b0;
    logic [5:0]  byte_offset_i = '0;
    logic [7:0]  byte_data_i = '0;
    logic        byte_ready_o;
    logic [14:0] ee_addr;
    logic [7:0]  ee_dout;
    logic        ee_drv, ee_ce_n, ee_we_n, ee_oe_n;
    logic [7:0]  ee_din = '0;
    logic        done_o;
    logic [1:0]  status_o;

    always #2 clk = ~clk;

    eeprom_page_writer #(
        .SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD),
        .GAP_LIMIT(GAP), .RD_DLY(RD), .POLL_MAX(PMAX)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .page_i(page_i),
        .count_i(count_i), .mode_i(mode_i), .busy_o(busy_o),
        .byte_valid_i(byte_valid_i), .byte_offset_i(byte_offset_i),
        .byte_data_i(byte_data_i), .byte_ready_o(byte_ready_o),
        .ee_addr_o(ee_addr), .ee_dout_o(ee_dout), .ee_drive_o(ee_drv),
        .ee_ce_n_o(ee_ce_n), .ee_we_n_o(ee_we_n), .ee_oe_n_o(ee_oe_n),
        .ee_poll_i({ee_din[7], ee_din[6]}), .done_o(done_o), .status_o(status_o)
    );

    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Device model and strobe monitor
    logic [7:0]  mem [int unsigned];
    int          busy_left = 0;
    int          busy_cfg = 0;
    bit          tog = 1'b0;
    int          oe_k = 0;
    logic [7:0]  rd_val = '0;
    int          wr_cnt = 0;
    logic        we_prev = 1'b1;
    int          pre_cnt = 0;
    int          low_cnt = 0;
    logic [14:0] fall_addr = '0;
    logic [7:0]  fall_data = '0;
    logic [8:0]  cur_page = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            we_prev = 1'b1; pre_cnt = 0; low_cnt = 0; oe_k = 0; ee_din = '0;
        end else begin
            if (we_prev && !ee_we_n) begin
                chk(!ee_ce_n && ee_oe_n && ee_drv, "R3", "strobe qualifiers", {ee_ce_n, ee_oe_n, ee_drv}, 3'b011);
                chk(pre_cnt == SETUP, "R3", "setup cycles", pre_cnt, SETUP);
                chk(ee_addr[14:6] == cur_page, "R2", "page bits", ee_addr[14:6], cur_page);
                fall_addr = ee_addr; fall_data = ee_dout; low_cnt = 1; pre_cnt = 0;
            end else if (!ee_we_n) begin
                low_cnt++;
                if (ee_addr != fall_addr || ee_dout != fall_data)
                    chk(1'b0, "R3", "address moved in pulse", ee_addr, fall_addr);
            end
            if (!we_prev && ee_we_n) begin
                chk(low_cnt == PULSE, "R3", "pulse width", low_cnt, PULSE);
                chk(!ee_ce_n && ee_drv, "R3", "hold after rise", {ee_ce_n, ee_drv}, 2'b01);
                mem[32'(ee_addr)] = ee_dout;
                wr_cnt++;
                busy_left = busy_cfg;
            end else if (busy_left > 0) begin
                busy_left--;
            end
            if (!ee_ce_n && ee_we_n && ee_drv) pre_cnt++;
            else if (ee_ce_n) pre_cnt = 0;
            if (!ee_oe_n && !ee_ce_n) begin
                oe_k++;
                if (oe_k == 1) begin
                    rd_val = mem.exists(32'(ee_addr)) ? mem[32'(ee_addr)] : 8'hFF;
                    if (busy_left > 0) begin
                        rd_val[7] = ~rd_val[7];
                        rd_val[6] = tog;
                        tog = ~tog;
                    end
                end
                ee_din = (oe_k >= RD) ? rd_val : ~rd_val;   // only valid from the sample cycle on
            end else begin
                oe_k = 0;
                ee_din = 8'h00;
            end
            we_prev = ee_we_n;
        end
    end

    int          done_cnt = 0;
    logic [1:0]  done_stat = '0;
    always @(posedge clk) begin
        if (rst_n && done_o) begin
            done_cnt++;
            done_stat = status_o;
        end
    end

    typedef struct packed {
        logic [6:0] n;
        logic       md;
        logic [9:0] bsy;
        logic [7:0] seed;
        logic [6:0] stall;
        logic [1:0] st;
        logic [6:0] nexp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{7'd1,  1'b0, 10'd30,  8'h3C, 7'd0,  2'd0, 7'd1},   // R6 bit7 clear
        '{7'd1,  1'b0, 10'd30,  8'hA5, 7'd0,  2'd0, 7'd1},   // R6 bit7 set
        '{7'd64, 1'b1, 10'd40,  8'h11, 7'd0,  2'd0, 7'd64},  // R7 full page
        '{7'd5,  1'b1, 10'd2,   8'h4E, 7'd0,  2'd0, 7'd5},   // R7 short busy
        '{7'd17, 1'b0, 10'd25,  8'hF0, 7'd10, 2'd0, 7'd17},  // R4 tolerated stall
        '{7'd3,  1'b0, 10'd500, 8'h81, 7'd0,  2'd1, 7'd3},   // R9 bit7 timeout
        '{7'd4,  1'b1, 10'd500, 8'h29, 7'd0,  2'd1, 7'd4},   // R9 toggle timeout
        '{7'd6,  1'b0, 10'd20,  8'h63, 7'd60, 2'd2, 7'd1}    // R5 underrun
    };

    logic [5:0] exp_off [64];
    logic [7:0] exp_dat [64];

    task automatic run_page(input logic [8:0] pg, input int n, input bit md,
                            input logic [7:0] seed, input int stall, input int bsy,
                            input bit poke, input int exp_st, input int exp_n);
        int d0;
        int w0;
        int acc;
        acc = 0;
        busy_cfg = bsy;
        cur_page = pg;
        d0 = done_cnt;
        w0 = wr_cnt;
        @(negedge clk);
        start_i = 1'b1; page_i = pg; count_i = 6'(n - 1); mode_i = md;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R1", "busy after start", busy_o, 1);
        for (int i = 0; i < n; i++) begin
            if (done_cnt != d0) break;
            if (i > 0) begin
                for (int s = 0; s < stall; s++) begin
                    @(negedge clk);
                    if (done_cnt != d0) break;
                end
                if (done_cnt != d0) break;
            end
            exp_off[i] = 6'((i * 37) + int'(seed));
            exp_dat[i] = 8'(int'(seed) + i * 3);
            byte_valid_i = 1'b1; byte_offset_i = exp_off[i]; byte_data_i = exp_dat[i];
            while (!byte_ready_o && done_cnt == d0) @(negedge clk);
            if (done_cnt != d0) begin byte_valid_i = 1'b0; break; end
            if (poke && i == 1) begin
                start_i = 1'b1; page_i = ~pg; count_i = 6'd0; mode_i = ~md;
            end
            @(negedge clk);
            byte_valid_i = 1'b0;
            start_i = 1'b0;
            acc++;
        end
        while (done_cnt == d0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(done_cnt - d0 == 1, "R10", "done pulses", done_cnt - d0, 1);
        chk(int'(done_stat) == exp_st, (exp_st == 2) ? "R5" : (exp_st == 1) ? "R9" : (md ? "R7" : "R6"),
            "status", done_stat, exp_st);
        chk(acc == exp_n, "R4", "bytes accepted", acc, exp_n);
        chk(wr_cnt - w0 == exp_n, "R4", "bytes written", wr_cnt - w0, exp_n);
        chk(busy_o == 1'b0, "R1", "idle after done", busy_o, 0);
        for (int k = 0; k < exp_n; k++) begin
            logic [7:0] got;
            got = mem.exists(32'({pg, exp_off[k]})) ? mem[32'({pg, exp_off[k]})] : 8'hXX;
            chk(got === exp_dat[k], "R2", "stored byte", got, exp_dat[k]);
        end
        while (busy_left > 0) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11 reset state
        chk({ee_ce_n, ee_we_n, ee_oe_n} == 3'b111, "R11", "strobes idle", {ee_ce_n, ee_we_n, ee_oe_n}, 7);
        chk({busy_o, done_o, byte_ready_o, ee_drv} == 4'b0, "R11", "flags low",
            {busy_o, done_o, byte_ready_o, ee_drv}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({ee_ce_n, ee_we_n, ee_oe_n, busy_o} == 4'b1110, "R11", "idle after reset",
            {ee_ce_n, ee_we_n, ee_oe_n, busy_o}, 4'b1110);

        for (int v = 0; v < NV; v++) begin
            run_page(9'(v * 41 + 3), int'(VECS[v].n), VECS[v].md, VECS[v].seed,
                     int'(VECS[v].stall), int'(VECS[v].bsy), 1'b0,
                     int'(VECS[v].st), int'(VECS[v].nexp));
        end

        // R12: second start mid-command must not change page, count or mode
        run_page(9'h155, 4, 1'b0, 8'h77, 0, 10, 1'b1, 0, 4);
        // R8: zero-busy read must return true data at the sample cycle
        run_page(9'h0AA, 2, 1'b0, 8'hC3, 0, 0, 1'b0, 0, 2);
        // R6 bit7 on the last byte differs from the first byte
        run_page(9'h1FF, 2, 1'b0, 8'h7F, 0, 15, 1'b0, 0, 2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule